// File: doc/BRIEF.md
# Transition-Count Signature Analyzer

This block compacts the serial response of a circuit under test into one short number. The response arrives one bit per clock. The block counts every change of value between consecutive samples, in either direction. At the end of the test the count is the signature of the circuit. The block compares that count with the value expected from a fault-free part and raises a pass flag when the two are equal.

A test begins with a one-cycle start pulse. The bit present in the start cycle is the first sample: it only sets the reference bit. Every later cycle samples the stream, up to and including the cycle that carries the end strobe. One cycle after that strobe the block presents the signature, a result-valid flag and the pass flag. These outputs then stay frozen until the next start.

Two different streams that hold the same number of changes give the same signature. This aliasing is accepted and is not reported. The counter saturates at its largest value, so an overflow can never wrap onto a small expected value and give a false pass.

Top module: `trans_sig_analyzer`

## Requirements
- R1: While `rst_i` is high, at the next clock edge `sig_o` becomes 0, `res_valid_o` becomes 0, `pass_o` becomes 0, and the stored reference bit is cleared.
- R2: The sample taken in the cycle where `start_i` is high only loads the reference bit and never adds to the count. `sig_o` reads 0 in the cycle after start, whatever the stream held before.
- R3: During an active test, each cycle whose `din_i` differs from the previous sample adds one to `sig_o`. A 0-to-1 change and a 1-to-0 change count alike.
- R4: The sample in the cycle carrying `end_i` is included in the count. `res_valid_o` is 0 during that cycle and reads 1 from the next cycle on.
- R5: `pass_o` is 1 exactly when the final count equals `expect_i` as sampled in the end cycle. Otherwise `pass_o` is 0.
- R6: With a counter width of W bits, the count stops at 2^W-1 and never wraps. For W=8, a stream of 299 changes gives 255.
- R7: After a test ends, `sig_o`, `pass_o` and `res_valid_o` hold their values until the next start. Changes of `din_i`, `expect_i` and `end_i` while no test runs have no effect on them.
- R8: A start pulse clears `sig_o`, `res_valid_o` and `pass_o` at the next edge, even in the middle of a running test. When `start_i` and `end_i` are high in the same cycle, the start wins and the end is ignored.
- R9: Two different streams with the same number of changes both pass against that number. No aliasing indication exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that begins a test; its cycle's bit is the first sample |
| end_i | input | 1 | End-of-test strobe; its cycle's bit is the last sample |
| din_i | input | 1 | Serial response bit from the circuit under test |
| expect_i | input | CNT_W | Expected signature, sampled in the end cycle |
| sig_o | output | CNT_W | Running and final transition count |
| res_valid_o | output | 1 | High from the cycle after end until the next start |
| pass_o | output | 1 | Final count matched the expected value |

## Verification
A test's signature and pass flag are due one clock after the cycle carrying the end strobe. The clear from a start pulse shows one clock after that pulse. The bench drives inputs on falling edges. A monitor, also on falling edges, pops the queued expectation the first time it sees the result-valid flag high, which is exactly one edge after the end cycle. Direct checks cover reset, the start-cycle clear, the idle freeze, and a start that shares its cycle with an end. Each of them samples on the falling edge that follows the relevant rising edge.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   typedef enum logic {
      TSA_IDLE   = 1'b0,
      TSA_ACTIVE = 1'b1
   } tsa_state_e;

   localparam int TSA_MIN_W = 2;
   localparam int TSA_MAX_W = 32;
endpackage

// File: rtl/tsa_edge_det.sv
module tsa_edge_det (
   input  logic clk_i,
   input  logic rst_i,
   input  logic load_i,
   input  logic sample_i,
   input  logic din_i,
   output logic toggle_o
);
   logic prev_q;
   logic ref_ok_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q   <= 1'b0;
         ref_ok_q <= 1'b0;
      end else if (load_i) begin
         prev_q   <= din_i;
         ref_ok_q <= 1'b1;
      end else if (sample_i) begin
         prev_q   <= din_i;
      end
   end

   assign toggle_o = sample_i && ref_ok_q && (din_i ^ prev_q);

   // R2
   load_no_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |-> !toggle_o);
endmodule

// File: rtl/tsa_sat_counter.sv
module tsa_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nxt_o
);
   localparam logic [W-1:0] MAX_VAL = '1;
   localparam logic [W-1:0] ONE     = W'(1);

   logic [W-1:0] cnt_q;
   logic         at_max;

   generate
      if (W == 1) begin : g_narrow
         assign at_max = cnt_q[0];
      end else begin : g_wide
         assign at_max = &cnt_q;
      end
   endgenerate

   always_comb begin
      if (clr_i)
         cnt_nxt_o = '0;
      else if (inc_i && !at_max)
         cnt_nxt_o = cnt_q + ONE;
      else
         cnt_nxt_o = cnt_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;

   // R6
   sat_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_o == MAX_VAL && !clr_i) |=> cnt_o == MAX_VAL);
   // R6
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !clr_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/tsa_result.sv
module tsa_result #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         clr_i,
   input  logic         capture_i,
   input  logic [W-1:0] final_i,
   input  logic [W-1:0] expect_i,
   output logic         valid_o,
   output logic         pass_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         valid_o <= 1'b0;
         pass_o  <= 1'b0;
      end else if (capture_i) begin
         valid_o <= 1'b1;
         pass_o  <= (final_i == expect_i);
      end
   end

   // R4
   valid_after_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (capture_i && !clr_i) |=> valid_o);
   // R7
   result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && !clr_i) |=> (valid_o && $stable(pass_o)));
endmodule

// File: rtl/trans_sig_analyzer.sv
module trans_sig_analyzer
   import tsa_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             end_i,
   input  logic             din_i,
   input  logic [CNT_W-1:0] expect_i,
   output logic [CNT_W-1:0] sig_o,
   output logic             res_valid_o,
   output logic             pass_o
);
   tsa_state_e       state_q;
   logic             sample;
   logic             capture;
   logic             toggle;
   logic [CNT_W-1:0] cnt_nxt;

   initial begin
      width_param_chk: assert (CNT_W >= TSA_MIN_W && CNT_W <= TSA_MAX_W)
         else $error("CNT_W out of range");
   end

   assign sample  = (state_q == TSA_ACTIVE) && !start_i;
   assign capture = sample && end_i;

   always_ff @(posedge clk_i) begin
      if (rst_i)        state_q <= TSA_IDLE;
      else if (start_i) state_q <= TSA_ACTIVE;
      else if (capture) state_q <= TSA_IDLE;
   end

   tsa_edge_det i_edge (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (start_i),
      .sample_i (sample),
      .din_i    (din_i),
      .toggle_o (toggle)
   );

   tsa_sat_counter #(.W(CNT_W)) i_cnt (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clr_i     (start_i),
      .inc_i     (toggle),
      .cnt_o     (sig_o),
      .cnt_nxt_o (cnt_nxt)
   );

   tsa_result #(.W(CNT_W)) i_res (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .clr_i     (start_i),
      .capture_i (capture),
      .final_i   (cnt_nxt),
      .expect_i  (expect_i),
      .valid_o   (res_valid_o),
      .pass_o    (pass_o)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk_i)
      rst_i |=> (sig_o == '0 && !res_valid_o && !pass_o));
   // R2
   first_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |=> (sig_o == '0 && !res_valid_o));
   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == TSA_IDLE && !start_i) |=> $stable(sig_o));
endmodule

// File: tb/test_trans_sig_analyzer.sv
module test_trans_sig_analyzer;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] cnt;
      logic         pass;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         endt = 1'b0;
   logic         din = 1'b0;
   logic [W-1:0] expv = '0;
   logic [W-1:0] sig;
   logic         vld;
   logic         pass;

   int   checks = 0;
   int   errors = 0;
   exp_t sb_q[$];
   logic stim[$];
   logic seen = 1'b0;

   always #2ns clk = ~clk;

   trans_sig_analyzer #(.CNT_W(W)) i_trans_sig_analyzer (
      .clk_i(clk), .rst_i(rst), .start_i(start), .end_i(endt), .din_i(din),
      .expect_i(expv), .sig_o(sig), .res_valid_o(vld), .pass_o(pass)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: computes expected signature and pushes it to the scoreboard
   task automatic run_test(input logic [W-1:0] exp_val, input string tag);
      int   n = stim.size();
      int   c = 0;
      exp_t e;
      for (int i = 1; i < n; i++)
         if (stim[i] != stim[i-1] && c < (1 << W) - 1) c++;
      e.cnt  = W'(c);
      e.pass = (W'(c) == exp_val);
      e.tag  = tag;
      sb_q.push_back(e);
      @(negedge clk);
      start = 1'b1; endt = 1'b0; din = stim[0];
      for (int i = 1; i < n; i++) begin
         @(negedge clk);
         start = 1'b0; din = stim[i];
         if (i == n - 1) begin endt = 1'b1; expv = exp_val; end
      end
      #1ns chk(vld == 1'b0, {tag, " R4 valid low in end cycle"}, int'(vld), 0);
      @(negedge clk);
      endt = 1'b0;
      @(negedge clk);
   endtask

   task automatic fill_alt(input int n, input logic first);
      stim.delete();
      for (int i = 0; i < n; i++) stim.push_back(first ^ logic'(i % 2));
   endtask

   // monitor: pops one expectation per rising result-valid
   always @(negedge clk) begin
      if (!rst && vld && !seen) begin
         exp_t e;
         seen = 1'b1;
         if (sb_q.size() == 0) begin
            chk(1'b0, "R4 unexpected result", int'(vld), 0);
         end else begin
            e = sb_q.pop_front();
            chk(sig == e.cnt, {e.tag, " signature"}, int'(sig), int'(e.cnt));
            chk(pass == e.pass, {e.tag, " R5 pass flag"}, int'(pass), int'(e.pass));
         end
      end
      if (!vld) seen = 1'b0;
   end

   initial begin
      #(4ns * 150000);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] hs;
      logic         hp;
      repeat (3) @(negedge clk);
      chk(sig == 0, "R1 reset sig", int'(sig), 0);
      chk(vld == 0, "R1 reset valid", int'(vld), 0);
      chk(pass == 0, "R1 reset pass", int'(pass), 0);
      rst = 1'b0;

      // R3: alternating stream, both edge directions
      fill_alt(10, 1'b0);
      run_test(8'd9, "R3 alternating");
      // R3: constant stream
      stim.delete();
      for (int i = 0; i < 20; i++) stim.push_back(1'b0);
      run_test(8'd0, "R3 constant zero");
      // R5: mismatch -> fail
      stim = '{0,0,1,1,1,0,0,1,0,1};
      run_test(8'd6, "R5 mismatch");
      // R2: previous stream ended at 1, new one starts at 0
      stim = '{0,0,0};
      run_test(8'd0, "R2 first sample");
      // R2 direct: start with din=1 after a 0-ended stream
      @(negedge clk); start = 1'b1; din = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(sig == 0, "R2 sig after start", int'(sig), 0);
      chk(vld == 0, "R8 valid cleared by start", int'(vld), 0);
      // R8: restart mid-run
      fill_alt(6, 1'b1);
      for (int i = 0; i < 6; i++) begin din = stim[i]; @(negedge clk); end
      stim = '{0,1};
      run_test(8'd1, "R8 restart");
      // R4: last (end cycle) bit counted
      stim = '{0,0,0,1};
      run_test(8'd1, "R4 end bit");
      // R6: saturation
      fill_alt(300, 1'b0);
      run_test(8'd255, "R6 saturate");
      fill_alt(300, 1'b0);
      run_test(8'd43, "R6 no wrap");
      // R9: aliasing
      stim = '{1,0,0,1,1,0};
      run_test(8'd3, "R9 alias a");
      stim = '{0,1,0,1};
      run_test(8'd3, "R9 alias b");
      // R7: idle freeze
      hs = sig; hp = pass;
      for (int i = 0; i < 6; i++) begin
         din = ~din; endt = logic'(i % 2); expv = W'(i);
         @(negedge clk);
      end
      endt = 1'b0;
      chk(sig == hs, "R7 sig frozen", int'(sig), int'(hs));
      chk(pass == hp, "R7 pass frozen", int'(pass), int'(hp));
      chk(vld == 1'b1, "R7 valid held", int'(vld), 1);
      // R8: start and end in the same cycle
      @(negedge clk); start = 1'b1; endt = 1'b1; din = 1'b0; expv = '0;
      @(negedge clk); start = 1'b0; endt = 1'b0;
      chk(vld == 0, "R8 end ignored with start", int'(vld), 0);
      @(negedge clk);
      chk(vld == 0, "R8 still running", int'(vld), 0);
      stim = '{1,1,0};
      run_test(8'd1, "R8 after collision");

      repeat (2) @(negedge clk);
      chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule